// File: doc/BRIEF.md
# Windowed Multichannel Spike Counter Bank

This block watches 32 parallel streams of digitized neural samples, all sharing one sample-enable. Every channel compares its sample against its own programmable amplitude level and counts the moments where the signal climbs above that level. The counts are accumulated in narrow saturating counters over an observation window. The window length is the base period multiplied by a power of two. The base period defaults to 2813 samples, which is about 90 ms at 31.25 kS/s per channel.

When a window closes, every channel's count is copied at once into a latched count vector, a one-cycle valid strobe is raised, and all counters restart together. A downstream rule engine reads the vector on the strobe. The levels are loaded one channel at a time through a small write port made of a channel address and a data byte.

Top module: `spk_count_bank`

## Requirements
- R1: After a synchronous active-low reset, `vec_valid` is 0, `cnt_vec` is all zeros, no window is in progress, and every channel level is 255, so no sample can produce a count.
- R2: On an enabled sample, a channel registers an event only when its sample is strictly greater than its level and its previous enabled sample was not. A sample equal to the level is not above it.
- R3: A signal that stays above the level for several enabled samples counts once. The channel re-arms only after an enabled sample at or below the level.
- R4: A channel counter stops at 15 and does not wrap, however many events arrive in one window.
- R5: A window boundary falls on every enabled sample at which the number of enabled samples since the previous boundary (or since reset) reaches `BASE_SAMPLES << win_shift` minus one. `vec_valid` is high for exactly the one cycle after each boundary sample.
- R6: At a boundary, `cnt_vec` takes the counts of the window just closed, with channel c in bits [4c+3:4c]. An event on the boundary sample itself counts as the first event of the new window.
- R7: A write with `thr_we` high loads `thr_data` into the level of channel `thr_addr`. An enabled sample in the same cycle as the write still uses the old level, and the next enabled sample uses the new one. Other channels keep their levels.
- R8: Cycles with `samp_en` low change no counter, no arming state and no window position, whatever `samp_data` holds.
- R9: `cnt_vec` holds its value in every cycle where `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | Marks the cycle that carries one sample on every channel |
| samp_data | input | NUM_CH*SAMP_W | Unsigned samples; channel c in bits [8c+7:8c] |
| thr_we | input | 1 | Level write strobe |
| thr_addr | input | $clog2(NUM_CH) | Channel whose level is written |
| thr_data | input | SAMP_W | New level value |
| win_shift | input | SHIFT_W | Window length is BASE_SAMPLES << win_shift enabled samples |
| cnt_vec | output | NUM_CH*4 | Latched counts of the last closed window |
| vec_valid | output | 1 | One-cycle strobe when cnt_vec is renewed |

## Verification
The bench targets the sample where an event and a window boundary coincide. A design that put that event into the closing window would show one count too many in the latched vector and one too few in the next. Samples held above the level and samples exactly at the level are used to catch level-triggered counting and off-by-one comparisons, which would inflate counts. A channel toggling across its level for a long window exposes a counter that wraps instead of holding at 15. Level writes made in the same cycle as a sample, and bursts of disabled cycles carrying large values, expose a design that applies writes too early or counts and advances the window without the enable.

// File: rtl/spk_pkg.sv
// Package: shared count type and saturating increment for the spike counter bank.
// Assumes every channel counter has the same fixed width.
package spk_pkg;
    localparam int CNT_W = 4;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = '1;

    // Add one unless already at the top value.
    function automatic cnt_t cnt_sat_inc(input cnt_t v);
        return (v == CNT_MAX) ? v : v + cnt_t'(1);
    endfunction
endpackage

// File: rtl/spk_thresh_bank.sv
// Module: per-channel level registers written one at a time through an address/data port.
// Assumes the address width covers NUM_CH; addresses at or beyond NUM_CH are dropped.
module spk_thresh_bank #(
    parameter int NUM_CH = 32,
    parameter int SAMP_W = 8,
    parameter logic [SAMP_W-1:0] THR_RST = '1,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [SAMP_W-1:0]        wr_data,
    output logic [NUM_CH*SAMP_W-1:0] thr_flat
);
    logic [SAMP_W-1:0] thr_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_thr
        // Hold one channel level; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[c] <= THR_RST;
            else if (wr_en && (32'(wr_addr) == c))
                thr_q[c] <= wr_data;
        end
        assign thr_flat[c*SAMP_W +: SAMP_W] = thr_q[c];
    end

    // R7: an in-range write is visible in the addressed register one cycle later.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_addr) < NUM_CH)) |=> thr_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spk_chan.sv
// Module: one channel's rising-crossing detector and saturating event counter.
// Assumes clr only arrives together with samp_en (window boundary on a sample).
module spk_chan
    import spk_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic [SAMP_W-1:0] sample,
    input  logic [SAMP_W-1:0] thr,
    input  logic              clr,
    output cnt_t              cnt
);
    logic above;
    logic prev_above;
    logic hit;

    // A hit is a sample above the level after one that was not.
    always_comb begin
        above = sample > thr;
        hit   = samp_en && above && !prev_above;
    end

    // Remember whether the last enabled sample was above the level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_above <= 1'b0;
        else if (samp_en)
            prev_above <= above;
    end

    // Count hits; a boundary restarts the count with this sample's hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= hit ? cnt_t'(1) : '0;
        else if (hit)
            cnt <= cnt_sat_inc(cnt);
    end

    // R3: two hits never come on back-to-back enabled samples.
    a_r3_one_per_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
    // R4: a full counter stays full until the window closes.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
    // R8: without an enable the counter is frozen.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(cnt));
endmodule

// File: rtl/spk_window_timer.sv
// Module: counts enabled samples and flags the sample that closes each window.
// Assumes BASE_SAMPLES >= 1; a shortened window closes on the next enabled sample.
module spk_window_timer #(
    parameter int BASE_SAMPLES = 2813,
    parameter int SHIFT_W = 3,
    localparam int MAX_SHIFT = (1 << SHIFT_W) - 1,
    localparam int TMR_W = $clog2(BASE_SAMPLES) + MAX_SHIFT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_en,
    input  logic [SHIFT_W-1:0] win_shift,
    output logic               boundary
);
    localparam logic [TMR_W-1:0] BASE_V = TMR_W'(BASE_SAMPLES);

    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] last_idx;

    // Index of the closing sample for the selected length.
    always_comb begin
        last_idx = (BASE_V << win_shift) - TMR_W'(1);
        boundary = samp_en && (tmr >= last_idx);
    end

    // Advance on each enabled sample, restart after the closing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (boundary)
            tmr <= '0;
        else if (samp_en)
            tmr <= tmr + TMR_W'(1);
    end

    // R5: the position restarts right after a boundary.
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> tmr == '0);
    // R8: no enable, no movement of the window position.
    a_r8_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(tmr));
endmodule

// File: rtl/spk_count_bank.sv
// Module: top of the windowed spike counter bank; one detector/counter per channel,
// a shared window timer and the latched count vector.
// Assumes samples are unsigned and arrive on all channels in the same enabled cycle.
module spk_count_bank
    import spk_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int SAMP_W = 8,
    parameter int SHIFT_W = 3,
    parameter int BASE_SAMPLES = 2813,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_en,
    input  logic [NUM_CH*SAMP_W-1:0] samp_data,
    input  logic                     thr_we,
    input  logic [ADDR_W-1:0]        thr_addr,
    input  logic [SAMP_W-1:0]        thr_data,
    input  logic [SHIFT_W-1:0]       win_shift,
    output logic [NUM_CH*CNT_W-1:0]  cnt_vec,
    output logic                     vec_valid
);
    logic [NUM_CH*SAMP_W-1:0] thr_flat;
    logic [NUM_CH*CNT_W-1:0]  live_cnt;
    logic                     boundary;

    spk_thresh_bank #(
        .NUM_CH (NUM_CH),
        .SAMP_W (SAMP_W)
    ) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (thr_we),
        .wr_addr  (thr_addr),
        .wr_data  (thr_data),
        .thr_flat (thr_flat)
    );

    spk_window_timer #(
        .BASE_SAMPLES (BASE_SAMPLES),
        .SHIFT_W      (SHIFT_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en   (samp_en),
        .win_shift (win_shift),
        .boundary  (boundary)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cnt_t ch_cnt;
        spk_chan #(
            .SAMP_W (SAMP_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .samp_en (samp_en),
            .sample  (samp_data[c*SAMP_W +: SAMP_W]),
            .thr     (thr_flat[c*SAMP_W +: SAMP_W]),
            .clr     (boundary),
            .cnt     (ch_cnt)
        );
        assign live_cnt[c*CNT_W +: CNT_W] = ch_cnt;
    end

    // Snapshot the closing window's counts and strobe once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_vec   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= boundary;
            if (boundary)
                cnt_vec <= live_cnt;
        end
    end

    // R9: the vector only moves together with the strobe.
    a_r9_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vec_valid) |-> $stable(cnt_vec));
    // R5: strobe follows a boundary sample by one cycle.
    a_r5_strobe_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> vec_valid);
    // R5: without an enable there can be no strobe in the next cycle.
    a_r5_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> !vec_valid);
endmodule

// File: tb/spk_count_bank_test.sv
module spk_count_bank_test;
    localparam int NCH  = 32;
    localparam int SW   = 8;
    localparam int CW   = 4;
    localparam int BASE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_en = 1'b0;
    logic [NCH*SW-1:0] samp_data = '0;
    logic              thr_we = 1'b0;
    logic [4:0]        thr_addr = '0;
    logic [SW-1:0]     thr_data = '0;
    logic [2:0]        win_shift = 3'd0;
    logic [NCH*CW-1:0] cnt_vec;
    logic              vec_valid;

    spk_count_bank #(.BASE_SAMPLES(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .samp_data(samp_data),
        .thr_we(thr_we), .thr_addr(thr_addr), .thr_data(thr_data),
        .win_shift(win_shift), .cnt_vec(cnt_vec), .vec_valid(vec_valid)
    );

    always #5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    string phase = "R2";
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;

    int m_thr [NCH];
    bit m_prev [NCH];
    int m_cnt [NCH];
    int m_tmr = 0;
    logic [NCH*CW-1:0] exp_q [$];
    logic [NCH*CW-1:0] last_vec = '0;

    // Model of the requirements, advanced once per enabled sample.
    task automatic model_sample(input logic [NCH*SW-1:0] d);
        int  len;
        bit  bnd;
        logic [NCH*CW-1:0] v;
        len = BASE << win_shift;
        bnd = (m_tmr >= len - 1);
        if (bnd) begin
            for (int c = 0; c < NCH; c++) v[c*CW +: CW] = CW'(m_cnt[c]);
            exp_q.push_back(v);
        end
        for (int c = 0; c < NCH; c++) begin
            bit ab, ev;
            ab = int'(d[c*SW +: SW]) > m_thr[c];
            ev = ab && !m_prev[c];
            m_prev[c] = ab;
            if (bnd) m_cnt[c] = ev ? 1 : 0;
            else if (ev && m_cnt[c] < 15) m_cnt[c]++;
        end
        m_tmr = bnd ? 0 : m_tmr + 1;
    endtask

    // Driver: one enabled sample, optionally with a level write in the same cycle.
    task automatic step(input logic [NCH*SW-1:0] d, input bit we, input int wa, input int wd);
        @(negedge clk);
        samp_en = 1'b1; samp_data = d;
        thr_we = we; thr_addr = 5'(wa); thr_data = SW'(wd);
        model_sample(d);
        if (we) m_thr[wa] = wd;
        @(posedge clk); #1;
        samp_en = 1'b0; thr_we = 1'b0;
    endtask

    // Driver: a disabled cycle with junk data (R8).
    task automatic idle(input logic [NCH*SW-1:0] junk);
        @(negedge clk);
        samp_en = 1'b0; samp_data = junk;
        @(posedge clk); #1;
    endtask

    task automatic write_thr(input int ch, input int val);
        @(negedge clk);
        thr_we = 1'b1; thr_addr = 5'(ch); thr_data = SW'(val);
        m_thr[ch] = val;
        @(posedge clk); #1;
        thr_we = 1'b0;
    endtask

    function automatic logic [NCH*SW-1:0] pat(input int s, input int kind);
        logic [NCH*SW-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            int v;
            case (kind)
                0: v = (s * 53 + c * 29) % 256;
                1: v = ((s + c) % 6 < 3) ? 250 : 0;
                2: v = (s % 2 == 0) ? 250 : 0;
                default: v = (s * 97 + c * 13 + 7) % 256;
            endcase
            d[c*SW +: SW] = SW'(v);
        end
        return d;
    endfunction

    // Monitor / scoreboard: pops expected vectors on each strobe.
    always @(negedge clk) begin
        if (mon_on && !finished) begin
            if (vec_valid) begin
                compared++;
                if (exp_q.size() == 0) begin
                    mismatched++;
                    $display("FAIL R5: unexpected strobe, actual vec_valid=1 expected 0");
                end else begin
                    logic [NCH*CW-1:0] e;
                    e = exp_q.pop_front();
                    if (cnt_vec !== e) begin
                        mismatched++;
                        $display("FAIL %s/R6: cnt_vec actual %h expected %h", phase, cnt_vec, e);
                    end
                    last_vec = e;
                end
            end else begin
                compared++;
                if (cnt_vec !== last_vec) begin
                    mismatched++;
                    $display("FAIL R9: cnt_vec moved without strobe, actual %h expected %h",
                             cnt_vec, last_vec);
                end
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #1500000;
        mismatched++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        summary();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_thr[c] = 255; m_prev[c] = 0; m_cnt[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state.
        compared++;
        if (vec_valid !== 1'b0 || cnt_vec !== '0) begin
            mismatched++;
            $display("FAIL R1: reset outputs actual valid=%b vec=%h expected 0/0", vec_valid, cnt_vec);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: default level 255 means no counts in a whole window.
        phase = "R1";
        win_shift = 3'd0;
        for (int s = 0; s < 8; s++) step(pat(s, 2), 1'b0, 0, 0);

        // R7: program distinct levels per channel.
        for (int c = 0; c < NCH; c++) write_thr(c, 100 + c);

        // R2: mixed values, including samples exactly at the level.
        phase = "R2";
        win_shift = 3'd1;
        for (int s = 0; s < 24; s++) begin
            logic [NCH*SW-1:0] d;
            d = pat(s, 0);
            d[0*SW +: SW] = SW'(100);
            d[1*SW +: SW] = (s % 2 == 0) ? SW'(102) : SW'(101);
            step(d, 1'b0, 0, 0);
        end

        // R3: signals held high across several samples.
        phase = "R3";
        for (int s = 0; s < 32; s++) step(pat(s, 1), 1'b0, 0, 0);

        // R4: toggle every sample in a 64-sample window to hit saturation.
        phase = "R4";
        win_shift = 3'd4;
        for (int s = 0; s < 140; s++) step(pat(s, 2), 1'b0, 0, 0);

        // R8: disabled cycles carrying large values interleaved with samples.
        phase = "R8";
        win_shift = 3'd0;
        for (int s = 0; s < 40; s++) begin
            step(pat(s, 3), 1'b0, 0, 0);
            if (s % 3 == 0) idle({NCH{8'hFF}});
            if (s % 5 == 0) begin idle({NCH{8'hF0}}); idle('0); end
        end

        // R7: write in the same cycle as a sample uses the old level.
        phase = "R7";
        for (int s = 0; s < 4; s++) step('0, 1'b0, 0, 0);
        step({NCH{8'd50}}, 1'b1, 5, 0);
        step({NCH{8'd50}}, 1'b0, 0, 0);
        step('0, 1'b1, 9, 10);
        step({NCH{8'd50}}, 1'b0, 0, 0);
        for (int s = 0; s < 8; s++) step(pat(s, 0), 1'b0, 0, 0);

        // R5/R6: longer window, then a shrink while mid-window.
        phase = "R5";
        win_shift = 3'd2;
        for (int s = 0; s < 40; s++) step(pat(s, 2), 1'b0, 0, 0);
        phase = "R6";
        win_shift = 3'd3;
        for (int s = 0; s < 20; s++) step(pat(s, 1), 1'b0, 0, 0);
        win_shift = 3'd1;
        for (int s = 0; s < 30; s++) step(pat(s, 3), 1'b0, 0, 0);

        // Drain, then every expected vector must have appeared (R5).
        repeat (4) idle('0);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R5: missing strobes, actual pending %0d expected 0", exp_q.size());
        end
        summary();
    end
endmodule